// File: doc/BRIEF.md
# Life Grid Engine with Blank-Time Snapshot

This block steps Conway-style cellular automaton generations on a small rectangular grid (16 by 16 cells by default). It keeps two working banks of cell flops. One bank holds the current generation. The other collects the next generation as the engine walks the grid one cell per clock. When the last cell has been evaluated, the two banks trade roles and a generation counter advances.

A renderer reads a third array, the display copy, so it never sees a half-computed generation. When the vertical-blank input rises, the engine halts. A copier then moves the current bank into the display copy, one cell per clock. The engine stays halted while blank is high and until the copy has finished, so it never writes its banks during that window. It then carries on from the cell where it stopped. Everything shares one clock, so no signal crosses between clock domains.

Top module: `life_blank_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block loads the current bank with a glider and clears the other bank, the display copy and the generation counter. The glider has live cells at linear indices 1, 18, 32, 33 and 34, where index = row*COLS + col. A display read during reset returns 0.
- R2: Each new cell follows the Life rules. A live cell with 2 or 3 live neighbours stays live. A dead cell with exactly 3 live neighbours becomes live. Every other cell is dead in the next generation.
- R3: Positions outside the grid count as dead neighbours. The grid does not wrap around its edges.
- R4: When not halted, the engine evaluates one cell per clock in index order, starting at index 0. The generation counter increments exactly once per ROWS*COLS active clocks, at the clock where the bank roles swap.
- R5: While the engine is halted, the generation counter and both working banks hold their values. The engine is halted when `vblank_i` is high or a copy is in progress.
- R6: A rising edge of `vblank_i` that is sampled while no copy is running starts a copy. On the following ROWS*COLS clocks, cells 0 to ROWS*COLS-1 of the current bank are copied into the display copy, one per clock.
- R7: A generation interrupted by a halt resumes at the cell where it stopped. The generation count at any time therefore equals the number of active clocks since reset, divided by ROWS*COLS and rounded down, taken modulo 2^GEN_W.
- R8: Outside a copy, the display copy does not change, whatever the engine is doing.
- R9: `vid_cell_o` shows, without any register delay, the display-copy cell at the linear index given by `vid_addr_i`.
- R10: The generation counter is GEN_W bits wide and wraps from its maximum value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock shared by the engine, the copier and the display read |
| rst_n | input | 1 | Synchronous reset, active low |
| vblank_i | input | 1 | Vertical blank from the display timing; its rising edge triggers a snapshot |
| vid_addr_i | input | $clog2(ROWS*COLS) | Linear cell index to read from the display copy |
| vid_cell_o | output | 1 | Display-copy cell at `vid_addr_i` (1 = live) |
| gen_count_o | output | GEN_W | Completed generations since reset, wrapping |

## Verification
The hardest case to reach from the ports is a blank period that lands part-way through a generation. The interrupted scan must then pick up at the same cell with no step lost or repeated. The glider must also be driven into the grid corner, and the counter taken past its wrap point, and none of these can be forced directly. The stimulus raises blank at deliberately uneven gaps (700 clocks, then 2000 plus a growing offset) across more than 64 generations, with the bench counter set to 6 bits. A cycle-accurate count of active clocks predicts the generation number at every clock. An independent Life model predicts every display cell after each snapshot.

// File: rtl/life_pkg.sv
`timescale 1ns/1ps
// life_pkg: shared helpers for the Life grid engine.
// Assumes: a neighbour count never exceeds 8, so 4 bits are enough.
package life_pkg;

    localparam int NBR_W = 4;

    // Rule for one cell: survival on 2 or 3 neighbours, birth on exactly 3.
    function automatic logic cell_rule(logic alive, logic [NBR_W-1:0] nbrs);
        return (nbrs == NBR_W'(3)) || (alive && (nbrs == NBR_W'(2)));
    endfunction

endpackage

// File: rtl/life_rule.sv
`timescale 1ns/1ps
// life_rule: works out the next state of one cell from the current bank.
// Assumes: cells are stored row-major (index = row*COLS + col) and
// positions outside the grid count as dead.
module life_rule #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic [CELLS-1:0] cur_vec_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             next_o
);
    import life_pkg::*;

    logic [NBR_W-1:0] nbr_cnt;
    int               row;
    int               col;

    // Count the live neighbours inside the grid, then apply the rule.
    always_comb begin
        row     = int'(idx_i) / COLS;
        col     = int'(idx_i) % COLS;
        nbr_cnt = '0;
        for (int dr = -1; dr <= 1; dr++) begin
            for (int dc = -1; dc <= 1; dc++) begin
                if (!(dr == 0 && dc == 0) &&
                    (row + dr >= 0) && (row + dr < ROWS) &&
                    (col + dc >= 0) && (col + dc < COLS)) begin
                    nbr_cnt = nbr_cnt +
                        NBR_W'(cur_vec_i[IDX_W'((row + dr) * COLS + (col + dc))]);
                end
            end
        end
        next_o = cell_rule(cur_vec_i[idx_i], nbr_cnt);
    end

endmodule

// File: rtl/life_engine.sv
`timescale 1ns/1ps
// life_engine: two working banks used in turn, scanned one cell per clock.
// It reads the current bank and writes the next one, then swaps the bank
// roles after the last cell and bumps the generation counter.
// Assumes: ROWS, COLS >= 3 (so the seed glider fits). freeze_i stops all
// state changes, and the scan resumes at the same cell when freeze_i drops.
module life_engine #(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int GEN_W = 16,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_cell_o,
    output logic [GEN_W-1:0] gen_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

    function automatic logic [CELLS-1:0] seed_pattern();
        logic [CELLS-1:0] s;
        s = '0;
        s[1]          = 1'b1;
        s[COLS + 2]   = 1'b1;
        s[2*COLS]     = 1'b1;
        s[2*COLS + 1] = 1'b1;
        s[2*COLS + 2] = 1'b1;
        return s;
    endfunction

    localparam logic [CELLS-1:0] SEED = seed_pattern();

    logic [CELLS-1:0] bank_a;
    logic [CELLS-1:0] bank_b;
    logic             cur_is_b;
    logic [IDX_W-1:0] scan_idx;
    logic [CELLS-1:0] cur_vec;
    logic             next_cell;

    assign cur_vec   = cur_is_b ? bank_b : bank_a;
    assign rd_cell_o = cur_vec[rd_idx_i];

    life_rule #(.ROWS(ROWS), .COLS(COLS)) u_rule (
        .cur_vec_i (cur_vec),
        .idx_i     (scan_idx),
        .next_o    (next_cell)
    );

    // Write the evaluated cell into whichever bank is not current.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_a <= SEED;
            bank_b <= '0;
        end else if (!freeze_i) begin
            if (cur_is_b) bank_a[scan_idx] <= next_cell;
            else          bank_b[scan_idx] <= next_cell;
        end
    end

    // Advance the scan index; swap banks and count a generation at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_idx <= '0;
            cur_is_b <= 1'b0;
            gen_o    <= '0;
        end else if (!freeze_i) begin
            if (scan_idx == LAST_IDX) begin
                scan_idx <= '0;
                cur_is_b <= ~cur_is_b;
                gen_o    <= gen_o + 1'b1;
            end else begin
                scan_idx <= scan_idx + 1'b1;
            end
        end
    end

    p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> ($stable(gen_o) && $stable(scan_idx) &&
                      $stable(bank_a) && $stable(bank_b)));

    p_gen_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && scan_idx == LAST_IDX) |=>
            (gen_o == GEN_W'($past(gen_o) + 1'b1)) && (scan_idx == '0));

    p_gen_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze_i && scan_idx != LAST_IDX) |=> $stable(gen_o));

    p_cur_bank_read_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_is_b) |=> $stable(bank_a));

endmodule

// File: rtl/life_snapshot.sv
`timescale 1ns/1ps
// life_snapshot: display copy of the grid. The rising edge of blank starts
// a copy that takes one cell per clock from the engine's current bank.
// Outside a copy the array is read-only. Reads are combinational.
// Assumes: the engine is halted while busy_o is high, so the source is stable.
module life_snapshot #(
    parameter int CELLS = 256,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vblank_i,
    input  logic             src_cell_i,
    output logic [IDX_W-1:0] src_idx_o,
    output logic             busy_o,
    input  logic [IDX_W-1:0] rd_addr_i,
    output logic             rd_cell_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

    logic [CELLS-1:0] video;
    logic             vblank_q;
    logic [IDX_W-1:0] ptr;
    logic             start;

    assign start     = vblank_i && !vblank_q && !busy_o;
    assign src_idx_o = ptr;
    assign rd_cell_o = video[rd_addr_i];

    // Remember last cycle's blank level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vblank_q <= 1'b0;
        else        vblank_q <= vblank_i;
    end

    // Copy sequencer: arm on the blank edge, walk every cell once.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            ptr    <= '0;
        end else if (start) begin
            busy_o <= 1'b1;
            ptr    <= '0;
        end else if (busy_o) begin
            if (ptr == LAST_IDX) begin
                busy_o <= 1'b0;
                ptr    <= '0;
            end else begin
                ptr <= ptr + 1'b1;
            end
        end
    end

    // Display array: written only by the copy sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n)      video <= '0;
        else if (busy_o) video[ptr] <= src_cell_i;
    end

    p_copy_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy_o && ptr == '0));

    p_copy_cell_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (video[$past(ptr)] == $past(src_cell_i)));

    p_copy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ptr == LAST_IDX) |=> !busy_o);

    p_video_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(video));

endmodule

// File: rtl/life_blank_top.sv
`timescale 1ns/1ps
// life_blank_top: Life engine plus blank-time snapshot, all on one clock.
// The engine is halted whenever blank is high or a copy is running.
// Assumes: vid_addr_i is below ROWS*COLS.
module life_blank_top #(
    parameter int ROWS  = 16,
    parameter int COLS  = 16,
    parameter int GEN_W = 16,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vblank_i,
    input  logic [IDX_W-1:0] vid_addr_i,
    output logic             vid_cell_o,
    output logic [GEN_W-1:0] gen_count_o
);
    logic             copy_busy;
    logic             freeze;
    logic [IDX_W-1:0] copy_idx;
    logic             copy_cell;

    assign freeze = vblank_i | copy_busy;

    life_engine #(.ROWS(ROWS), .COLS(COLS), .GEN_W(GEN_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_i  (freeze),
        .rd_idx_i  (copy_idx),
        .rd_cell_o (copy_cell),
        .gen_o     (gen_count_o)
    );

    life_snapshot #(.CELLS(CELLS)) u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .vblank_i   (vblank_i),
        .src_cell_i (copy_cell),
        .src_idx_o  (copy_idx),
        .busy_o     (copy_busy),
        .rd_addr_i  (vid_addr_i),
        .rd_cell_o  (vid_cell_o)
    );

    p_copy_sees_frozen_gen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        copy_busy |=> $stable(gen_count_o));

endmodule

// File: tb/tb_life_blank_top.sv
`timescale 1ns/1ps
// Scoreboard bench: read-out tasks queue expected display cells; a monitor
// pops each one and compares it with vid_cell_o.
module tb_life_blank_top;
    localparam int ROWS  = 16;
    localparam int COLS  = 16;
    localparam int GEN_W = 6;
    localparam int CELLS = ROWS * COLS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             vblank = 1'b0;
    logic [7:0]       vid_addr = '0;
    logic             vid_cell;
    logic [GEN_W-1:0] gen_count;

    always #2 clk = ~clk;

    life_blank_top #(.ROWS(ROWS), .COLS(COLS), .GEN_W(GEN_W)) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .vblank_i    (vblank),
        .vid_addr_i  (vid_addr),
        .vid_cell_o  (vid_cell),
        .gen_count_o (gen_count)
    );

    typedef struct { int addr; bit val; string tag; } exp_t;
    exp_t q[$];

    int checks = 0;
    int fails = 0;
    int steps = 0;
    int gen_mis = 0;
    bit done = 0;
    bit [CELLS-1:0] model;
    bit [CELLS-1:0] last_snap;
    int model_gens = 0;

    function automatic bit [CELLS-1:0] life_next(bit [CELLS-1:0] s);
        bit [CELLS-1:0] n;
        n = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int cnt;
                cnt = 0;
                for (int dr = -1; dr <= 1; dr++)
                    for (int dc = -1; dc <= 1; dc++)
                        if (!(dr == 0 && dc == 0) && r+dr >= 0 && r+dr < ROWS &&
                            c+dc >= 0 && c+dc < COLS)
                            cnt += int'(s[(r+dr)*COLS + c+dc]);
                n[r*COLS+c] = (cnt == 3) || (s[r*COLS+c] && cnt == 2);
            end
        end
        return n;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: count active engine clocks (R7) and track the counter each cycle.
    task automatic tick();
        @(posedge clk);
        if (rst_n && !vblank) steps++;
        @(negedge clk);
        if (rst_n && gen_count != GEN_W'(steps / CELLS)) gen_mis++;
    endtask

    // Driver: present every address and queue its expected cell (R9).
    task automatic read_video(bit [CELLS-1:0] exp, string tag);
        for (int a = 0; a < CELLS; a++) begin
            vid_addr = 8'(a);
            q.push_back('{a, exp[a], tag});
            tick();
        end
        wait (q.size() == 0);
    endtask

    // Raise blank long enough for the copy, predict the generation, read back.
    task automatic snapshot(string tag);
        vblank = 1'b1;
        repeat (260) tick();
        while (model_gens < steps / CELLS) begin
            model = life_next(model);
            model_gens++;
        end
        check(gen_count == GEN_W'(model_gens), {tag, " R4 R10 gen count"},
              int'(gen_count), model_gens % (1 << GEN_W));
        last_snap = model;
        read_video(model, tag);
        vblank = 1'b0;
    endtask

    // Monitor: one expected item per clock, compared after the edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            check(vid_cell == e.val && int'(vid_addr) == e.addr,
                  $sformatf("%s R9 cell %0d", e.tag, e.addr), int'(vid_cell), int'(e.val));
        end
    end

    initial begin
        int g;
        model = '0;
        model[1] = 1; model[18] = 1; model[32] = 1; model[33] = 1; model[34] = 1;
        rst_n = 1'b0;
        repeat (4) tick();
        check(gen_count == '0, "R1 reset gen count", int'(gen_count), 0);
        read_video('0, "R1 reset display zero");
        rst_n = 1'b1;
        snapshot("R1 R6 seed glider");
        repeat (700) tick();
        snapshot("R2 R6 mid-generation snapshot");
        g = int'(gen_count);
        snapshot("R5 R6 frozen snapshot");
        check(int'(gen_count) == g, "R5 counter held through blank", int'(gen_count), g);
        repeat (300) tick();
        read_video(last_snap, "R8 display held while engine runs");
        for (int k = 0; k < 8; k++) begin
            repeat (2000 + 37 * k) tick();
            snapshot("R2 R3 R7 R10 long run");
        end
        check(model_gens >= 64, "R10 wrap reached", model_gens, 64);
        check(gen_mis == 0, "R7 R4 counter vs active clocks", gen_mis, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule